// File: doc/BRIEF.md
# Encoder Velocity Measurement Unit

This block turns a stream of decoded encoder steps into a speed figure. A down-counting window timer is loaded from a programmable period value; while it runs, every one-cycle step pulse from the upstream quadrature decoder adds one to a live step count. When the timer has run out, the live count is frozen into a capture register, the live count restarts and the timer reloads for the next window. The capture therefore holds the number of steps seen in the last complete window, which is proportional to shaft speed.

Each window end raises a one-cycle window-done pulse. In the same cycle a second pulse reports an underspeed condition when the captured count is below a programmable threshold. Motor control firmware uses this pair for periodic speed sampling and for stall detection. A clear strobe discards the window in progress and starts a fresh, full-length one. The live timer, the live count and the last capture can all be read at any time.

Top module: `enc_vel_meter`

## Requirements
- R1: While `rst_n` is low, `tmr_o`, `cnt_o`, `cap_o`, `win_done_o` and `slow_o` are all 0. The first clock edge after release loads `period_i` into the timer without a capture and without `win_done_o`.
- R2: While the timer is nonzero and no clear is requested, `tmr_o` drops by exactly one per clock.
- R3: On the clock edge where the timer reads 0, the timer loads the current `period_i`, and `win_done_o` is high for exactly the following cycle. A window thus lasts `period_i`+1 cycles.
- R4: On that same edge, `cap_o` takes the value `cnt_o` had just before the edge. Otherwise `cap_o` holds.
- R5: A step pulse in the capture cycle is counted in the new window, so `cnt_o` is 1 after the edge, not 0.
- R6: Outside capture and clear, each cycle with `step_i` high adds one to `cnt_o`.
- R7: The live count saturates at 2^CNT_W-1 and does not wrap. This applies when the parameter SATURATE is 1, which is the default.
- R8: `slow_o` pulses only with `win_done_o`, and only when the new capture is strictly below `thresh_i` as sampled on the capture edge. Changes of `thresh_i` between captures have no effect.
- R9: `vel_clr_i` takes priority over expiry. It sets `cnt_o` to 0, discarding a pulse in the same cycle, and reloads the timer from `period_i`. It leaves `cap_o` unchanged and produces no `win_done_o` or `slow_o`.
- R10: With `period_i` equal to 0, a capture occurs on every clock edge, and each capture holds the pulse of the cycle before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | One-cycle decoded encoder step pulse |
| vel_clr_i | input | 1 | Clear live count and restart the window |
| period_i | input | TMR_W | Window timer reload value |
| thresh_i | input | CNT_W | Underspeed threshold |
| tmr_o | output | TMR_W | Live window timer |
| cnt_o | output | CNT_W | Live step count |
| cap_o | output | CNT_W | Step count of the last full window |
| win_done_o | output | 1 | One-cycle window-end pulse |
| slow_o | output | 1 | One-cycle capture-below-threshold pulse |

## Verification
The properties assume that `period_i` and `thresh_i` are steady on the clock edge where they are sampled, and that `step_i` carries at most one step per cycle. In both the random and the directed phases, the bench changes these inputs only on the falling edge. It changes the period only occasionally, so both long windows and zero-length windows occur. It also sets the threshold both above and below the counts a window can reach, so both outcomes of the compare are seen.

// File: rtl/enc_vel_pkg.sv
package enc_vel_pkg;

  // Window timer phase: priming after reset, then free running.
  typedef enum logic {
    PH_PRIME = 1'b0,
    PH_RUN   = 1'b1
  } tmr_phase_e;

  // Event produced by the window timer in one cycle.
  typedef struct packed {
    logic expire;   // timer read 0 while running: capture now
    logic restart;  // timer loaded without capture (clear or prime)
  } tmr_evt_t;

endpackage

// File: rtl/vel_window_timer.sv
module vel_window_timer
  import enc_vel_pkg::*;
#(
  parameter int TMR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [TMR_W-1:0] period_i,
  output logic [TMR_W-1:0] tmr_o,
  output tmr_evt_t         evt_o
);

  localparam logic [TMR_W-1:0] TMR_ONE  = TMR_W'(1);
  localparam logic [TMR_W-1:0] TMR_ZERO = '0;

  tmr_phase_e       phase_q, phase_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             at_zero;

  assign at_zero = (tmr_q == TMR_ZERO);

  always_comb begin
    phase_d       = phase_q;
    tmr_d         = tmr_q;
    evt_o.expire  = 1'b0;
    evt_o.restart = 1'b0;
    if (clr_i) begin
      // clear wins over expiry: full new window, no capture
      phase_d       = PH_RUN;
      tmr_d         = period_i;
      evt_o.restart = 1'b1;
    end else if (phase_q == PH_PRIME) begin
      phase_d       = PH_RUN;
      tmr_d         = period_i;
      evt_o.restart = 1'b1;
    end else if (at_zero) begin
      tmr_d        = period_i;
      evt_o.expire = 1'b1;
    end else begin
      tmr_d = tmr_q - TMR_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_PRIME;
      tmr_q   <= TMR_ZERO;
    end else begin
      phase_q <= phase_d;
      tmr_q   <= tmr_d;
    end
  end

  assign tmr_o = tmr_q;

endmodule

// File: rtl/vel_step_counter.sv
module vel_step_counter #(
  parameter int CNT_W    = 32,
  parameter bit SATURATE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             clr_i,
  input  logic             expire_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             cnt_en;

  generate
    if (SATURATE) begin : g_sat
      assign cnt_inc = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + CNT_ONE;
    end else begin : g_wrap
      assign cnt_inc = cnt_q + CNT_ONE;
    end
  endgenerate

  // register enable: any of clear, restart or step changes the count
  assign cnt_en = clr_i | expire_i | step_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = CNT_ZERO;
    end else if (expire_i) begin
      // step in the capture cycle belongs to the new window
      cnt_d = step_i ? CNT_ONE : CNT_ZERO;
    end else if (step_i) begin
      cnt_d = cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_ZERO;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/vel_capture_cmp.sv
module vel_capture_cmp #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             done_o,
  output logic             slow_o
);

  logic [CNT_W-1:0] cap_q, cap_d;
  logic             done_q, done_d;
  logic             slow_q, slow_d;

  always_comb begin
    cap_d  = cap_q;
    done_d = 1'b0;
    slow_d = 1'b0;
    if (cap_en_i) begin
      cap_d  = cnt_i;
      done_d = 1'b1;
      // compare only at capture time, against the outgoing count
      slow_d = (cnt_i < thresh_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
    end else if (cap_en_i) begin
      cap_q <= cap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      slow_q <= 1'b0;
    end else begin
      done_q <= done_d;
      slow_q <= slow_d;
    end
  end

  assign cap_o  = cap_q;
  assign done_o = done_q;
  assign slow_o = slow_q;

endmodule

// File: rtl/enc_vel_meter.sv
module enc_vel_meter
  import enc_vel_pkg::*;
#(
  parameter int TMR_W    = 32,
  parameter int CNT_W    = 32,
  parameter bit SATURATE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             vel_clr_i,
  input  logic [TMR_W-1:0] period_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic [TMR_W-1:0] tmr_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cap_o,
  output logic             win_done_o,
  output logic             slow_o
);

  tmr_evt_t         tmr_evt;
  logic [CNT_W-1:0] cnt_live;

  vel_window_timer #(
    .TMR_W (TMR_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (vel_clr_i),
    .period_i (period_i),
    .tmr_o    (tmr_o),
    .evt_o    (tmr_evt)
  );

  vel_step_counter #(
    .CNT_W    (CNT_W),
    .SATURATE (SATURATE)
  ) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_i   (step_i),
    .clr_i    (vel_clr_i),
    .expire_i (tmr_evt.expire),
    .cnt_o    (cnt_live)
  );

  vel_capture_cmp #(
    .CNT_W (CNT_W)
  ) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en_i (tmr_evt.expire),
    .cnt_i    (cnt_live),
    .thresh_i (thresh_i),
    .cap_o    (cap_o),
    .done_o   (win_done_o),
    .slow_o   (slow_o)
  );

  assign cnt_o = cnt_live;

endmodule

// File: rtl/enc_vel_meter_chk.sv
module enc_vel_meter_chk #(
  parameter int TMR_W    = 32,
  parameter int CNT_W    = 32,
  parameter bit SATURATE = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step_i,
  input logic             vel_clr_i,
  input logic [TMR_W-1:0] period_i,
  input logic [CNT_W-1:0] thresh_i,
  input logic [TMR_W-1:0] tmr_o,
  input logic [CNT_W-1:0] cnt_o,
  input logic [CNT_W-1:0] cap_o,
  input logic             win_done_o,
  input logic             slow_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R2
  tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_o != '0 && !vel_clr_i) |=> tmr_o == $past(tmr_o) - TMR_W'(1));

  // R3
  reload_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_done_o |-> tmr_o == $past(period_i));

  // R4
  cap_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_done_o |-> cap_o == $past(cnt_o));

  // R6
  step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && tmr_o != '0 && !vel_clr_i && cnt_o != CNT_MAX) |=>
      cnt_o == $past(cnt_o) + CNT_W'(1));

  // R8
  slow_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slow_o |-> win_done_o);

  // R8
  slow_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_done_o |-> slow_o == (cap_o < $past(thresh_i)));

  // R9
  clr_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vel_clr_i |=> (cnt_o == '0 && !win_done_o && $stable(cap_o)));

  generate
    if (SATURATE) begin : g_sat_chk
      // R7
      cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == CNT_MAX && tmr_o != '0 && !vel_clr_i) |=> cnt_o == CNT_MAX);
    end
  endgenerate

endmodule

bind enc_vel_meter enc_vel_meter_chk #(
  .TMR_W    (TMR_W),
  .CNT_W    (CNT_W),
  .SATURATE (SATURATE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .step_i     (step_i),
  .vel_clr_i  (vel_clr_i),
  .period_i   (period_i),
  .thresh_i   (thresh_i),
  .tmr_o      (tmr_o),
  .cnt_o      (cnt_o),
  .cap_o      (cap_o),
  .win_done_o (win_done_o),
  .slow_o     (slow_o)
);

// File: tb/test_enc_vel_meter.sv
`timescale 1ns/1ps
module test_enc_vel_meter;

  localparam int TMR_W = 32;
  localparam int CNT_W = 6;
  localparam logic [CNT_W-1:0] MAXC = {CNT_W{1'b1}};

  logic             clk;
  logic             rst_n;
  logic             step_i;
  logic             vel_clr_i;
  logic [TMR_W-1:0] period_i;
  logic [CNT_W-1:0] thresh_i;
  logic [TMR_W-1:0] tmr_o;
  logic [CNT_W-1:0] cnt_o;
  logic [CNT_W-1:0] cap_o;
  logic             win_done_o;
  logic             slow_o;

  enc_vel_meter #(.TMR_W(TMR_W), .CNT_W(CNT_W), .SATURATE(1'b1)) i_enc_vel_meter (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .vel_clr_i(vel_clr_i),
    .period_i(period_i), .thresh_i(thresh_i), .tmr_o(tmr_o), .cnt_o(cnt_o),
    .cap_o(cap_o), .win_done_o(win_done_o), .slow_o(slow_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  // expected-state model
  logic [TMR_W-1:0] m_tmr;
  logic             m_prime;
  logic [CNT_W-1:0] m_cnt, m_cap;
  logic             m_done, m_slow;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == MAXC) ? MAXC : v + 1'b1;
  endfunction

  task automatic model_step();
    logic [CNT_W-1:0] old_cnt;
    old_cnt = m_cnt;
    m_done = 1'b0;
    m_slow = 1'b0;
    if (vel_clr_i) begin
      m_tmr = period_i; m_prime = 1'b0; m_cnt = '0;
    end else if (m_prime) begin
      m_tmr = period_i; m_prime = 1'b0;
      if (step_i) m_cnt = sat_inc(m_cnt);
    end else if (m_tmr == '0) begin
      m_tmr  = period_i;
      m_cap  = old_cnt;
      m_cnt  = step_i ? CNT_W'(1) : '0;
      m_done = 1'b1;
      m_slow = (old_cnt < thresh_i);
    end else begin
      m_tmr = m_tmr - 1;
      if (step_i) m_cnt = sat_inc(m_cnt);
    end
  endtask

  task automatic compare(input string req);
    n_vec++;
    if (tmr_o !== m_tmr) begin n_bad++;
      $display("FAIL %s tmr_o act=%0d exp=%0d", req, tmr_o, m_tmr); end
    if (cnt_o !== m_cnt) begin n_bad++;
      $display("FAIL %s cnt_o act=%0d exp=%0d", req, cnt_o, m_cnt); end
    if (cap_o !== m_cap) begin n_bad++;
      $display("FAIL %s cap_o act=%0d exp=%0d", req, cap_o, m_cap); end
    if (win_done_o !== m_done) begin n_bad++;
      $display("FAIL %s win_done_o act=%0b exp=%0b", req, win_done_o, m_done); end
    if (slow_o !== m_slow) begin n_bad++;
      $display("FAIL %s slow_o act=%0b exp=%0b", req, slow_o, m_slow); end
  endtask

  // called at a falling edge: drive, advance model, wait one cycle, compare
  task automatic cyc(input logic stp, input logic clr, input string req);
    step_i = stp;
    vel_clr_i = clr;
    model_step();
    @(negedge clk);
    compare(req);
  endtask

  task automatic expect_now(input logic exp, input logic act, input string what, input string req);
    n_vec++;
    if (act !== exp) begin n_bad++;
      $display("FAIL %s %s act=%0b exp=%0b", req, what, act, exp); end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int seed;
    seed = 32'h5eed_c0de;
    void'($urandom(seed));
    rst_n = 1'b0; step_i = 1'b0; vel_clr_i = 1'b0;
    period_i = 32'd5; thresh_i = 6'd3;
    m_tmr = '0; m_prime = 1'b1; m_cnt = '0; m_cap = '0; m_done = 1'b0; m_slow = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    compare("R1");
    rst_n = 1'b1;
    // R1 priming edge: loads period, no window end
    cyc(1'b0, 1'b0, "R1");
    // R2 R3 R4 R8: window of 6 cycles with 2 steps (2 < 3 -> slow)
    cyc(1'b1, 1'b0, "R6");
    cyc(1'b0, 1'b0, "R2");
    cyc(1'b1, 1'b0, "R6");
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, "R3");
    // R5 step in the capture cycle lands in the new window
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, "R6");
    cyc(1'b1, 1'b0, "R5");
    // R8 threshold changed mid-window only matters at capture edge
    thresh_i = 6'd0;
    cyc(1'b0, 1'b0, "R8");
    thresh_i = 6'd40;
    for (int i = 0; i < 10; i++) cyc(1'b1, 1'b0, "R8");
    // R9 clear with coincident step, mid-window
    cyc(1'b1, 1'b0, "R9");
    cyc(1'b1, 1'b1, "R9");
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, "R9");
    // R9 clear exactly when timer would expire
    while (tmr_o != '0) cyc(1'b1, 1'b0, "R9");
    cyc(1'b0, 1'b1, "R9");
    // R7 saturation: long window, step every cycle
    period_i = 32'd100;
    cyc(1'b0, 1'b1, "R7");
    for (int i = 0; i < 101; i++) cyc(1'b1, 1'b0, "R7");
    expect_now(1'b1, cap_o == MAXC, "cap_o saturated", "R7");
    // R10 zero period: capture each cycle
    period_i = 32'd0;
    for (int i = 0; i < 12; i++) cyc(1'(i % 3 != 0), 1'b0, "R10");
    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 99) < 3) period_i = TMR_W'($urandom_range(0, 20));
      if ($urandom_range(0, 99) < 5) thresh_i = CNT_W'($urandom_range(0, 12));
      cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 99) < 2), "R2/R3 random");
    end
    // R1 reset again mid-run
    rst_n = 1'b0;
    #1;
    m_tmr = '0; m_prime = 1'b1; m_cnt = '0; m_cap = '0; m_done = 1'b0; m_slow = 1'b0;
    compare("R1");
    @(negedge clk);
    rst_n = 1'b1;
    period_i = 32'd2;
    cyc(1'b1, 1'b0, "R1");
    for (int i = 0; i < 6; i++) cyc(1'b1, 1'b0, "R3");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule